// File: doc/BRIEF.md
# Multi-Block Card Data Transfer Sequencer

This block moves payload between a 16-bit word FIFO and a byte-wide card data stream. Software programs a per-block byte length and a block count. A command-issue pulse marked as a data transfer then clears the FIFO, fixes the direction and starts the sequencer. When receiving, incoming card bytes are packed two per FIFO word, first byte in the low half. When transmitting, each FIFO word is split into its low byte and then its high byte. A block whose length is odd ends on a half-filled word. The next block always begins on a fresh word.

The sequencer counts bytes down within each block and counts blocks down within the transfer. Both counters are visible live on output ports. When the last byte of a block moves, the byte counter reloads. When the last block finishes, the block counter reloads, the sequencer goes idle and a one-cycle completion pulse is raised. The host's status register latches this pulse as its bit 3. Receive pauses at the start of a word while the FIFO holds more words than the almost-full threshold. Transmit pauses while the FIFO is empty.

The controller has five states. `ST_IDLE` is the state out of reset. `ST_RX_LO` waits for the low byte of a receive word and `ST_RX_HI` waits for its high byte. `ST_TX_LO` sends the low byte of a transmit word and `ST_TX_HI` sends its high byte. Its transitions are:
- start-data, from any state: go to `ST_RX_LO` or `ST_TX_LO`, chosen by direction.
- start-other, from any state: go to `ST_IDLE`.
- low-to-high: a low byte moves while the block still has bytes left.
- word-done: the high byte moves, so go back to the low state.
- block-end: the last byte of a block moves, so go to the low state.
- transfer-end: the last byte of the last block moves, so go to `ST_IDLE`.

Top module: `blk_xfer_seq`

## Requirements
- R1: A length write sets the block length, and the live byte counter, to `wr_val`+1 bytes. A count write sets the block count to `wr_val`+1. The value 2047 gives 2048.
- R2: A count write reloads the block counter from the new count and the byte counter from the programmed length, whatever their current values.
- R3: A `start` pulse with `start_data`=1 pulses `fifo_clr` in that cycle, makes `active` high from the next cycle and latches the direction (`start_rx`=1 receive, 0 transmit). With `start_data`=0 the block is idle from the next cycle.
- R4: Packing uses the low half of a word for the first byte, bits 7:0, and the high half for the second, bits 15:8. A receive word is pushed when its second byte arrives, or on its first byte if that byte ends the block; in that case bits 15:8 are zero. A transmit word is popped after its high byte is sent, or after its low byte if that byte ends the block.
- R5: In receive, `rx_ready` is low in the low-byte state while `fifo_level` > `af_level`. In transmit, `tx_valid` is low in the low-byte state while `fifo_level` = 0.
- R6: When a byte moves with the byte counter at 1, the byte counter reloads to the block length and the block counter decrements.
- R7: When that happens with the block counter also at 1, the block counter reloads to the block count, `xfer_done` pulses in that cycle and `active` is low from the next cycle.
- R8: `byte_left` and `blk_left` always show the live counters.
- R9: After reset the block is idle with both counters zero. At most one byte moves per clock, only when valid and ready are both high. `rx_ready` and `tx_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| len_wr | input | 1 | Write block length from `wr_val` |
| cnt_wr | input | 1 | Write block count from `wr_val` |
| wr_val | input | 11 | Register write value (stored value minus one) |
| start | input | 1 | Command-issue pulse |
| start_data | input | 1 | Issued command is a data transfer |
| start_rx | input | 1 | Direction: 1 receive, 0 transmit |
| af_level | input | 5 | Receive almost-full threshold in words |
| fifo_level | input | 6 | FIFO fill count in words |
| fifo_rdata | input | 16 | FIFO head word (first-word fall-through) |
| fifo_push | output | 1 | Push `fifo_wdata` |
| fifo_wdata | output | 16 | Packed receive word |
| fifo_pop | output | 1 | Pop the head word |
| fifo_clr | output | 1 | Clear FIFO pointers |
| rx_valid | input | 1 | Card byte available |
| rx_data | input | 8 | Card byte |
| rx_ready | output | 1 | Sequencer takes the card byte |
| tx_valid | output | 1 | Byte offered to card |
| tx_data | output | 8 | Byte to card |
| tx_ready | input | 1 | Card takes the byte |
| active | output | 1 | Transfer in progress |
| xfer_done | output | 1 | Completion pulse (status bit 3 set) |
| byte_left | output | 12 | Live byte counter |
| blk_left | output | 12 | Live block counter |

## Verification
The sharpest coincidence is that the end of a word, the end of a block and the end of the transfer can all fall in a single byte handshake. With an odd block length, that one handshake must push a half-filled word (or pop a word after only its low byte), reload both counters, raise `xfer_done` and drop `active` on the next edge. A second coincidence is receive back-pressure: the threshold comparison and the FIFO level change from a push land in consecutive cycles. The bench provokes this with a threshold of one word and a slow drain. A behavioural model with its own queue and integer counters predicts every output on every clock, and any divergence in push data, pop timing, ready/valid, counters or the completion pulse is reported against the requirement it breaks.

// File: rtl/bxs_pkg.sv
package bxs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RX_LO = 3'd1,
        ST_RX_HI = 3'd2,
        ST_TX_LO = 3'd3,
        ST_TX_HI = 3'd4
    } bxs_state_e;
endpackage

// File: rtl/bxs_counters.sv
// Byte-in-block and block-in-transfer down counters with programmed reload values.
module bxs_counters #(
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             len_wr,
    input  logic             cnt_wr,
    input  logic [LEN_W-1:0] wr_val,
    input  logic             byte_step,
    output logic [LEN_W:0]   byte_left,
    output logic [LEN_W:0]   blk_left,
    output logic             last_byte,
    output logic             last_blk
);
    logic [LEN_W:0] blen_q, nblk_q, byte_q, blk_q;
    logic [LEN_W:0] wr_plus1;

    assign wr_plus1  = {1'b0, wr_val} + 1'b1;
    assign last_byte = (byte_q == {{LEN_W{1'b0}}, 1'b1});
    assign last_blk  = (blk_q  == {{LEN_W{1'b0}}, 1'b1});
    assign byte_left = byte_q;
    assign blk_left  = blk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blen_q <= '0;
            nblk_q <= '0;
            byte_q <= '0;
            blk_q  <= '0;
        end else if (len_wr || cnt_wr) begin
            if (len_wr) begin
                blen_q <= wr_plus1;
                byte_q <= wr_plus1;
            end
            if (cnt_wr) begin
                nblk_q <= wr_plus1;
                blk_q  <= wr_plus1;
                byte_q <= len_wr ? wr_plus1 : blen_q;
            end
        end else if (byte_step) begin
            if (last_byte) begin
                byte_q <= blen_q;
                blk_q  <= last_blk ? nblk_q : blk_q - 1'b1;
            end else begin
                byte_q <= byte_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/bxs_fsm.sv
// Word packing / unpacking controller between FIFO and byte stream.
module bxs_fsm
    import bxs_pkg::*;
#(
    parameter int FIFO_AW = 5,
    parameter int AF_W    = 5,
    parameter int BYTE_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                start_data,
    input  logic                start_rx,
    input  logic                last_byte,
    input  logic                last_blk,
    input  logic [FIFO_AW:0]    fifo_level,
    input  logic [AF_W-1:0]     af_level,
    input  logic [2*BYTE_W-1:0] fifo_rdata,
    input  logic                rx_valid,
    input  logic [BYTE_W-1:0]   rx_data,
    input  logic                tx_ready,
    output bxs_state_e          state,
    output logic                rx_ready,
    output logic                tx_valid,
    output logic [BYTE_W-1:0]   tx_data,
    output logic                fifo_push,
    output logic [2*BYTE_W-1:0] fifo_wdata,
    output logic                fifo_pop,
    output logic                fifo_clr,
    output logic                byte_step,
    output logic                done
);
    localparam int LVL_W = FIFO_AW + 1;

    bxs_state_e state_q, state_d;
    logic [BYTE_W-1:0] lo_q;
    logic rx_hs, tx_hs, rx_room, tx_have;

    assign state   = state_q;
    assign rx_room = (fifo_level <= LVL_W'(af_level));
    assign tx_have = (fifo_level != '0);

    // state register and low-byte holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            lo_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_RX_LO && rx_hs) lo_q <= rx_data;
        end
    end

    // outputs
    always_comb begin
        rx_ready   = 1'b0;
        tx_valid   = 1'b0;
        tx_data    = '0;
        fifo_push  = 1'b0;
        fifo_wdata = '0;
        fifo_pop   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RX_LO: begin
                rx_ready   = !start && rx_room;
                fifo_push  = rx_valid && rx_ready && last_byte;
                fifo_wdata = {{BYTE_W{1'b0}}, rx_data};
            end
            ST_RX_HI: begin
                rx_ready   = !start;
                fifo_push  = rx_valid && rx_ready;
                fifo_wdata = {rx_data, lo_q};
            end
            ST_TX_LO: begin
                tx_valid = !start && tx_have;
                tx_data  = fifo_rdata[BYTE_W-1:0];
                fifo_pop = tx_valid && tx_ready && last_byte;
            end
            ST_TX_HI: begin
                tx_valid = !start;
                tx_data  = fifo_rdata[2*BYTE_W-1:BYTE_W];
                fifo_pop = tx_valid && tx_ready;
            end
            default: ;
        endcase
    end

    assign rx_hs     = rx_valid && rx_ready;
    assign tx_hs     = tx_valid && tx_ready;
    assign byte_step = rx_hs || tx_hs;
    assign done      = byte_step && last_byte && last_blk;
    assign fifo_clr  = start && start_data;

    // transitions
    always_comb begin
        state_d = state_q;
        if (start) begin
            if (start_data) state_d = start_rx ? ST_RX_LO : ST_TX_LO;
            else            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_RX_LO: if (rx_hs) begin
                    if (last_byte) state_d = last_blk ? ST_IDLE : ST_RX_LO;
                    else           state_d = ST_RX_HI;
                end
                ST_RX_HI: if (rx_hs)
                    state_d = (last_byte && last_blk) ? ST_IDLE : ST_RX_LO;
                ST_TX_LO: if (tx_hs) begin
                    if (last_byte) state_d = last_blk ? ST_IDLE : ST_TX_LO;
                    else           state_d = ST_TX_HI;
                end
                ST_TX_HI: if (tx_hs)
                    state_d = (last_byte && last_blk) ? ST_IDLE : ST_TX_LO;
                default: state_d = ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
    import bxs_pkg::*;
#(
    parameter int LEN_W   = 11,
    parameter int FIFO_AW = 5,
    parameter int AF_W    = 5,
    parameter int BYTE_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                len_wr,
    input  logic                cnt_wr,
    input  logic [LEN_W-1:0]    wr_val,
    input  logic                start,
    input  logic                start_data,
    input  logic                start_rx,
    input  logic [AF_W-1:0]     af_level,
    input  logic [FIFO_AW:0]    fifo_level,
    input  logic [2*BYTE_W-1:0] fifo_rdata,
    output logic                fifo_push,
    output logic [2*BYTE_W-1:0] fifo_wdata,
    output logic                fifo_pop,
    output logic                fifo_clr,
    input  logic                rx_valid,
    input  logic [BYTE_W-1:0]   rx_data,
    output logic                rx_ready,
    output logic                tx_valid,
    output logic [BYTE_W-1:0]   tx_data,
    input  logic                tx_ready,
    output logic                active,
    output logic                xfer_done,
    output logic [LEN_W:0]      byte_left,
    output logic [LEN_W:0]      blk_left
);
    bxs_state_e state;
    logic byte_step, last_byte, last_blk;

    bxs_counters #(.LEN_W(LEN_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .len_wr    (len_wr),
        .cnt_wr    (cnt_wr),
        .wr_val    (wr_val),
        .byte_step (byte_step),
        .byte_left (byte_left),
        .blk_left  (blk_left),
        .last_byte (last_byte),
        .last_blk  (last_blk)
    );

    bxs_fsm #(.FIFO_AW(FIFO_AW), .AF_W(AF_W), .BYTE_W(BYTE_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_data (start_data),
        .start_rx   (start_rx),
        .last_byte  (last_byte),
        .last_blk   (last_blk),
        .fifo_level (fifo_level),
        .af_level   (af_level),
        .fifo_rdata (fifo_rdata),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .tx_ready   (tx_ready),
        .state      (state),
        .rx_ready   (rx_ready),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .fifo_push  (fifo_push),
        .fifo_wdata (fifo_wdata),
        .fifo_pop   (fifo_pop),
        .fifo_clr   (fifo_clr),
        .byte_step  (byte_step),
        .done       (xfer_done)
    );

    assign active = (state != ST_IDLE);
endmodule

// File: rtl/bxs_chk.sv
module bxs_chk
    import bxs_pkg::*;
#(
    parameter int LEN_W   = 11,
    parameter int FIFO_AW = 5,
    parameter int AF_W    = 5
) (
    input logic             clk,
    input logic             rst_n,
    input bxs_state_e       state,
    input logic             len_wr,
    input logic             cnt_wr,
    input logic             rx_valid,
    input logic             rx_ready,
    input logic             tx_valid,
    input logic             tx_ready,
    input logic             fifo_push,
    input logic             fifo_pop,
    input logic             fifo_clr,
    input logic [FIFO_AW:0] fifo_level,
    input logic [AF_W-1:0]  af_level,
    input logic             active,
    input logic             xfer_done,
    input logic [LEN_W:0]   blk_left,
    input logic [LEN_W:0]   byte_left
);
    localparam int LVL_W = FIFO_AW + 1;

    // R9
    one_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_ready && tx_valid));
    // R4
    push_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> (rx_valid && rx_ready && !fifo_pop));
    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !active);
    // R5
    rx_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RX_LO && fifo_level > LVL_W'(af_level)) |-> !rx_ready);
    // R5
    tx_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TX_LO && fifo_level == '0) |-> !tx_valid);
    // R6
    blk_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((rx_valid && rx_ready) || (tx_valid && tx_ready)) && !len_wr && !cnt_wr
         && byte_left == 1 && blk_left > 1) |=> (blk_left == $past(blk_left) - 1'b1));
    // R3
    clr_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |=> active);
endmodule

bind blk_xfer_seq bxs_chk #(.LEN_W(LEN_W), .FIFO_AW(FIFO_AW), .AF_W(AF_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state),
    .len_wr     (len_wr),
    .cnt_wr     (cnt_wr),
    .rx_valid   (rx_valid),
    .rx_ready   (rx_ready),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .fifo_push  (fifo_push),
    .fifo_pop   (fifo_pop),
    .fifo_clr   (fifo_clr),
    .fifo_level (fifo_level),
    .af_level   (af_level),
    .active     (active),
    .xfer_done  (xfer_done),
    .blk_left   (blk_left),
    .byte_left  (byte_left)
);

// File: tb/blk_xfer_seq_test.sv
module blk_xfer_seq_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic len_wr = 0, cnt_wr = 0, start = 0, start_data = 0, start_rx = 0;
    logic [10:0] wr_val = '0;
    logic [4:0]  af_level = 5'd31;
    logic [5:0]  fifo_level = '0;
    logic [15:0] fifo_rdata = '0;
    logic fifo_push, fifo_pop, fifo_clr, rx_ready, tx_valid, active, xfer_done;
    logic [15:0] fifo_wdata;
    logic [7:0]  tx_data;
    logic rx_valid = 0, tx_ready = 0;
    logic [7:0]  rx_data = '0;
    logic [11:0] byte_left, blk_left;

    int n_chk = 0, n_bad = 0;
    logic [15:0] q[$];
    bit rx_en = 0, tx_en = 0, drain_en = 0;
    int drain_div = 4, cyc = 0;

    // behavioural model
    bit m_act = 0, m_rx = 0, m_hi = 0;
    logic [7:0] m_lo = '0;
    int m_byte = 0, m_blk = 0, m_blen = 0, m_nblk = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    blk_xfer_seq uut (.*);

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic void refresh();
        fifo_level = 6'(q.size());
        fifo_rdata = (q.size() > 0) ? q[0] : 16'h0;
    endfunction

    // per-cycle reference comparison and model update
    initial begin
        bit e_rxr, e_txv, rxhs, txhs, hs, lastb, e_push, e_pop, e_done, e_clr;
        bit s_push, s_pop, s_clr, s_rxhs;
        logic [15:0] e_wd, s_wd, hd;
        bit n_act, n_rx, n_hi;
        logic [7:0] n_lo;
        int n_byte, n_blk, n_blen, n_nblk, lvl;
        forever begin
            @(negedge clk);
            #2;
            s_push = 0; s_pop = 0; s_clr = 0; s_rxhs = 0; s_wd = '0;
            n_act = m_act; n_rx = m_rx; n_hi = m_hi; n_lo = m_lo;
            n_byte = m_byte; n_blk = m_blk; n_blen = m_blen; n_nblk = m_nblk;
            if (rst_n) begin
                lvl = q.size();
                hd = (lvl > 0) ? q[0] : 16'h0;
                e_rxr = !start && m_act && m_rx && (m_hi || lvl <= int'(af_level));
                e_txv = !start && m_act && !m_rx && (m_hi || lvl != 0);
                rxhs = e_rxr && rx_valid;
                txhs = e_txv && tx_ready;
                hs = rxhs || txhs;
                lastb = (m_byte == 1);
                e_push = rxhs && (m_hi || lastb);
                e_wd = m_hi ? {rx_data, m_lo} : {8'h00, rx_data};
                e_pop = txhs && (m_hi || lastb);
                e_done = hs && lastb && (m_blk == 1);
                e_clr = start && start_data;
                chk("R5 rx_ready", 32'(rx_ready), 32'(e_rxr));
                chk("R5 tx_valid", 32'(tx_valid), 32'(e_txv));
                if (e_txv) chk("R4 tx_data", 32'(tx_data), 32'(m_hi ? hd[15:8] : hd[7:0]));
                chk("R4 push", 32'(fifo_push), 32'(e_push));
                if (e_push) chk("R4 wdata", 32'(fifo_wdata), 32'(e_wd));
                chk("R4 pop", 32'(fifo_pop), 32'(e_pop));
                chk("R7 done", 32'(xfer_done), 32'(e_done));
                chk("R3 clr", 32'(fifo_clr), 32'(e_clr));
                chk("R3 active", 32'(active), 32'(m_act));
                chk("R8 byte_left", 32'(byte_left), 32'(m_byte));
                chk("R8 blk_left", 32'(blk_left), 32'(m_blk));
                s_push = fifo_push; s_wd = fifo_wdata; s_pop = fifo_pop;
                s_clr = fifo_clr; s_rxhs = rx_valid && rx_ready;
                if (len_wr) begin n_blen = int'(wr_val) + 1; n_byte = n_blen; end
                if (cnt_wr) begin n_nblk = int'(wr_val) + 1; n_blk = n_nblk; n_byte = n_blen; end
                if (!len_wr && !cnt_wr && hs) begin
                    if (lastb) begin
                        n_byte = m_blen;
                        n_blk = (m_blk == 1) ? m_nblk : m_blk - 1;
                    end else n_byte = m_byte - 1;
                end
                if (hs) begin
                    if (lastb || m_hi) n_hi = 0;
                    else begin n_hi = 1; n_lo = rx_data; end
                end
                if (e_done) n_act = 0;
                if (start) begin n_act = start_data; n_rx = start_rx; n_hi = 0; end
            end
            @(posedge clk);
            #1;
            m_act = n_act; m_rx = n_rx; m_hi = n_hi; m_lo = n_lo;
            m_byte = n_byte; m_blk = n_blk; m_blen = n_blen; m_nblk = n_nblk;
            if (s_clr) q.delete();
            if (s_push) q.push_back(s_wd);
            if (s_pop && q.size() > 0) void'(q.pop_front());
            if (drain_en && (cyc % drain_div == 0) && q.size() > 0) void'(q.pop_front());
            refresh();
            if (s_rxhs) rx_data = rx_data + 8'd1;
            cyc++;
            rx_valid = rx_en && (cyc % 7 != 2);
            tx_ready = tx_en && (cyc % 5 != 4);
        end
    end

    task automatic wr_len(int v);
        @(negedge clk); len_wr = 1; wr_val = 11'(v);
        @(negedge clk); len_wr = 0;
    endtask

    task automatic wr_cnt(int v);
        @(negedge clk); cnt_wr = 1; wr_val = 11'(v);
        @(negedge clk); cnt_wr = 0;
    endtask

    task automatic do_start(bit data, bit rx);
        @(negedge clk); start = 1; start_data = data; start_rx = rx;
        @(negedge clk); start = 0;
    endtask

    task automatic load_words(int n, int base);
        @(negedge clk);
        for (int i = 0; i < n; i++) q.push_back(16'(base + i));
        refresh();
    endtask

    task automatic wait_idle(string tag);
        int k = 0;
        do begin @(negedge clk); k++; end while (active && k < 5000);
        #3;
        chk(tag, 32'(active), 32'h0);
    endtask

    task automatic probe(string tag, logic [31:0] act, logic [31:0] exp);
        @(negedge clk); #3;
        chk(tag, act, exp);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        #3;
        chk("R9 reset active", 32'(active), 32'h0);
        chk("R9 reset byte_left", 32'(byte_left), 32'h0);
        chk("R9 reset blk_left", 32'(blk_left), 32'h0);
        @(negedge clk); rst_n = 1;

        // R1 programming
        wr_len(3); wr_cnt(1);
        probe("R1 length 4", 32'(byte_left), 32'd4);
        chk("R1 count 2", 32'(blk_left), 32'd2);

        // receive even length, 2 blocks of 4 bytes
        rx_data = 8'h10;
        do_start(1, 1);
        rx_en = 1;
        wait_idle("R7 rx even finishes");
        rx_en = 0;
        chk("R4 rx word count", 32'(q.size()), 32'd4);
        chk("R4 rx first word", 32'(q[0]), 32'h1110);
        chk("R7 byte reload", 32'(byte_left), 32'd4);
        chk("R7 blk reload", 32'(blk_left), 32'd2);

        // receive odd length with threshold stall, 3 blocks of 3 bytes
        wr_len(2); wr_cnt(2);
        af_level = 5'd1; drain_en = 1; drain_div = 6;
        rx_data = 8'h40;
        do_start(1, 1);
        rx_en = 1;
        wait_idle("R5 rx stalled run finishes");
        rx_en = 0;
        repeat (40) @(negedge clk);
        drain_en = 0; af_level = 5'd31;
        chk("R6 blk reload odd", 32'(blk_left), 32'd3);

        // transmit even length, 2 blocks of 6 bytes
        wr_len(5); wr_cnt(1);
        do_start(1, 0);
        load_words(6, 16'hA100);
        tx_en = 1;
        wait_idle("R7 tx even finishes");
        chk("R4 tx all popped", 32'(q.size()), 32'd0);

        // transmit odd length with empty stall, 2 blocks of 5 bytes
        wr_len(4);
        wr_cnt(1);
        do_start(1, 0);
        load_words(2, 16'hB200);
        repeat (20) @(negedge clk);
        #3;
        chk("R5 tx empty stall active", 32'(active), 32'h1);
        chk("R5 tx empty stall valid", 32'(tx_valid), 32'h0);
        load_words(4, 16'hB202);
        wait_idle("R7 tx odd finishes");
        chk("R4 tx odd all popped", 32'(q.size()), 32'd0);
        tx_en = 0;

        // non-data command and abort
        do_start(0, 1);
        probe("R3 non-data idle", 32'(active), 32'h0);
        do_start(1, 1);
        rx_en = 1;
        repeat (3) @(negedge clk);
        rx_en = 0;
        do_start(0, 0);
        probe("R3 abort idle", 32'(active), 32'h0);
        wr_cnt(0);
        probe("R2 byte reload", 32'(byte_left), 32'd5);
        chk("R2 blk reload", 32'(blk_left), 32'd1);
        wr_len(2047);
        probe("R1 max length", 32'(byte_left), 32'd2048);

        repeat (4) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R9 act=hung exp=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule